// File: doc/BRIEF.md
# SPI-attached UART register interface

This block is the host-facing side of a single-channel UART that is reached over SPI. The host runs 16-bit full-duplex frames. The two top bits of each frame it sends pick one of four operations:
- load the line configuration;
- read the line configuration back;
- hand a character to the transmitter;
- take a character from the receiver.

The word that comes back always opens with two live flags. One says a received character is waiting. The other says the transmit holding register is free.

Inside sit a 14-bit configuration register, a receive queue of parameterised depth (16 by default), a one-character transmit holding register, an RTS output and an active-low interrupt line. The serial bit engine is not part of the block. It talks to the block through a byte-level handshake:
- The engine takes a queued character when it raises `tx_ready`.
- The engine delivers a received character with a one-cycle `rx_valid` pulse.

It reads the configuration from `line_cfg`.

The SPI inputs are synchronised into the system clock. SPI mode 0 is used: the block samples MOSI on rising SCLK and changes MISO after falling SCLK. The clock ratio must leave at least four system clock cycles per SCLK half period.

Top module: `spi_uart_regif`

## Requirements
- R1: Operation codes in frame bits 15:14 are: 11 load configuration from bits 13:0, 01 read configuration (returned in response bits 13:0), 10 transmit-data write, 00 receive-data read.
- R2: Every response carries bit 15 = a received character was queued when chip select fell, and bit 14 = the transmit holding register was empty then. For both write operations, response bits 13:0 are zero.
- R3: Completing a configuration load discards every queued received character.
- R4: A transmit-data write with bit 10 clear queues bits 8:0 (bit 8 is the caller-computed parity bit) on `tx_word` and raises `tx_valid` until `tx_ready` is seen. A write arriving while the register is still occupied is dropped.
- R5: Every transmit-data write drives `rts_out` from bit 9. When bit 10 is set, no character is queued.
- R6: A receive-data read returns the character in bits 7:0, its received parity bit in bit 8, the synchronised `cts_in` level in bit 9 and the framing-error flag in bit 10. Bits 13:11 are zero.
- R7: A receive-data read removes one character only if response bit 15 was set for that frame. Otherwise it returns zero in bits 8:0 and bit 10, and the queue is unchanged.
- R8: Received characters come out in arrival order. The queue holds FIFO_DEPTH entries, and a character arriving when it is full is discarded.
- R9: With configuration bit 13 set, the queue holds at most one character.
- R10: A frame in which chip select rises before the 16th rising SCLK edge changes no register and no queue entry.
- R11: `irq_n` is low exactly one clock after either of two conditions holds: configuration bit 10 is set and a character is queued, or bit 11 is set and the holding register is empty. Otherwise `irq_n` is high.
- R12: A frame takes effect on the third clock edge after the edge that first registers its 16th SCLK rise. A received character arriving in that same cycle is kept after a configuration-load flush, and it is also kept alongside the removal done by a receive-data read.
- R13: After reset the configuration is zero, `irq_n` is high, and `rts_out`, `tx_valid` and `spi_miso` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low, frames a 16-bit word |
| spi_mosi | input | 1 | SPI data from host, most significant bit first |
| spi_miso | output | 1 | SPI data to host, most significant bit first |
| irq_n | output | 1 | Active-low interrupt request |
| line_cfg | output | 14 | Configuration register contents for the bit engine |
| rts_out | output | 1 | Request-to-send level written by the host |
| cts_in | input | 1 | Clear-to-send level reported to the host |
| tx_valid | output | 1 | Transmit holding register occupied |
| tx_word | output | 9 | Character to send, bit 8 is the parity bit |
| tx_ready | input | 1 | Bit engine takes the held character |
| rx_valid | input | 1 | One-cycle pulse: a received character is offered |
| rx_word | input | 9 | Received character, bit 8 is the received parity bit |
| rx_ferr | input | 1 | Framing error for the offered character |

## Verification
The receive queue can be changed by a finishing frame and by the bit engine in the same clock cycle. This happens in two ways: a configuration-load flush meeting an incoming character, and a receive-data removal meeting an incoming character. The bench provokes each collision by raising `rx_valid` in the precise cycle in which the frame commits, counted from the SCLK edge it drives. It then judges the outcome only through later receive-data reads. After the flush collision, exactly the new character must remain. After the removal collision, the old head must come out first and the new character second, with nothing after them.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;

  localparam int WORD_W = 16;
  localparam int CFG_W  = 14;
  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } op_e;

  // configuration bits read by this block
  localparam int CB_ONE_SLOT = 13;
  localparam int CB_TXE_IRQ  = 11;
  localparam int CB_RXD_IRQ  = 10;

  // data word bit positions
  localparam int DB_LINE = 9;   // RTS out on writes, CTS in on reads
  localparam int DB_AUX  = 10;  // RTS-only on writes, framing error on reads

  typedef struct packed {
    logic       ferr;
    logic [8:0] chr;   // bit 8: parity bit, 7:0: character
  } rx_entry_t;

endpackage

// File: rtl/uart_spi_shifter.sv
module uart_spi_shifter
  import spi_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [1:0]        flags_in,
  input  logic [CFG_W-1:0]  payload_in,
  output logic              miso,
  output logic              frame_open,
  output logic              hdr_stb,
  output op_e               hdr_op,
  output logic              done_q,
  output logic [WORD_W-1:0] word_q
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(1);

  logic sclk_m, sclk_s, sclk_d;
  logic cs_m, cs_s, cs_d;
  logic mosi_m, mosi_s;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;

  logic cs_fall, sclk_rise, sclk_fall, shift_en;

  assign cs_fall   = cs_d & ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign shift_en  = ~cs_s & ~cs_fall & sclk_rise & (bit_cnt != CNT_FULL);

  assign frame_open = cs_fall;
  assign hdr_stb    = shift_en & (bit_cnt == CNT_HDR);
  assign hdr_op     = op_e'({rx_sr[0], mosi_s});
  assign miso       = tx_sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_m <= 1'b0; sclk_s <= 1'b0; sclk_d <= 1'b0;
      cs_m   <= 1'b1; cs_s   <= 1'b1; cs_d   <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sclk_m <= sclk;   sclk_s <= sclk_m; sclk_d <= sclk_s;
      cs_m   <= cs_n;   cs_s   <= cs_m;   cs_d   <= cs_s;
      mosi_m <= mosi;   mosi_s <= mosi_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
      end else if (cs_fall) begin
        bit_cnt <= '0;
        tx_sr   <= {flags_in, {CFG_W{1'b0}}};
      end else if (shift_en) begin
        rx_sr   <= {rx_sr[WORD_W-3:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_HDR)
          tx_sr[WORD_W-2:1] <= payload_in;
        if (bit_cnt == CNT_LAST) begin
          done_q <= 1'b1;
          word_q <= {rx_sr, mosi_s};
        end
      end else if (sclk_fall && bit_cnt != '0) begin
        tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R10
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (bit_cnt == '0)); // R10
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !done_q); // R10

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import spi_uart_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      flush,
  input  logic      push,
  input  rx_entry_t din,
  input  logic      pop,
  input  logic      single_slot,
  output rx_entry_t head,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C   = CW'(1);
  localparam logic [AW-1:0] LAST_A  = AW'(DEPTH - 1);

  rx_entry_t mem [DEPTH];
  logic [AW-1:0] wp, rp, wr_addr;
  logic [CW-1:0] limit;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_A) ? '0 : p + 1'b1;
  endfunction

  assign limit   = single_slot ? ONE_C : DEPTH_C;
  assign do_pop  = pop & (count != '0) & ~flush;
  assign do_push = push & (flush | (count < limit) | do_pop);
  assign wr_addr = flush ? '0 : wp;

  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_addr] <= din;
    head <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      rp    <= '0;
      wp    <= do_push ? bump('0) : '0;
      count <= do_push ? ONE_C : '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flush && !push) |=> (count == '0)); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !flush && count >= limit) |=> (count == $past(count))); // R8
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (rst)
    single_slot |-> (count <= ONE_C)); // R9

endmodule

// File: rtl/uart_spi_regs.sv
module uart_spi_regs
  import spi_uart_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_open,
  input  logic              hdr_stb,
  input  op_e               hdr_op,
  input  logic              done_q,
  input  logic [WORD_W-1:0] word_q,
  input  logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input  rx_entry_t         fifo_head,
  input  logic              cts_in,
  input  logic              tx_ready,
  output logic [1:0]        flags,
  output logic [CFG_W-1:0]  payload,
  output logic              fifo_flush,
  output logic              fifo_pop,
  output logic              fifo_single,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              rts_q,
  output logic              thr_full,
  output logic [CHAR_W-1:0] thr_word,
  output logic              irq_n
);

  logic cts_m, cts_s;
  logic r_at_start;
  logic have_rx;
  op_e  done_op;
  logic commit_cfg, commit_dat, rts_only;
  logic irq_cond;

  assign have_rx    = (fifo_count != '0);
  assign flags      = {have_rx, ~thr_full};
  assign done_op    = op_e'(word_q[WORD_W-1 -: 2]);
  assign commit_cfg = done_q & (done_op == OP_WR_CFG);
  assign commit_dat = done_q & (done_op == OP_WR_DATA);
  assign rts_only   = word_q[DB_AUX];
  assign fifo_flush = commit_cfg;
  assign fifo_pop   = done_q & (done_op == OP_RD_DATA) & r_at_start;
  assign fifo_single = cfg_q[CB_ONE_SLOT];
  assign irq_cond   = (cfg_q[CB_RXD_IRQ] & have_rx) | (cfg_q[CB_TXE_IRQ] & ~thr_full);

  always_comb begin
    payload = '0;
    unique case (hdr_op)
      OP_RD_CFG:  payload = cfg_q;
      OP_RD_DATA: begin
        payload[DB_LINE] = cts_s;
        if (r_at_start) begin
          payload[DB_AUX]       = fifo_head.ferr;
          payload[CHAR_W-1:0]   = fifo_head.chr;
        end
      end
      default:    payload = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_m      <= 1'b0;
      cts_s      <= 1'b0;
      r_at_start <= 1'b0;
      cfg_q      <= '0;
      rts_q      <= 1'b0;
      thr_full   <= 1'b0;
      thr_word   <= '0;
      irq_n      <= 1'b1;
    end else begin
      cts_m <= cts_in;
      cts_s <= cts_m;
      irq_n <= ~irq_cond;
      if (frame_open)
        r_at_start <= have_rx;
      if (commit_cfg)
        cfg_q <= word_q[CFG_W-1:0];
      if (commit_dat)
        rts_q <= word_q[DB_LINE];
      if (commit_dat && !rts_only && !thr_full) begin
        thr_word <= word_q[CHAR_W-1:0];
        thr_full <= 1'b1;
      end else if (thr_full && tx_ready) begin
        thr_full <= 1'b0;
      end
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> have_rx); // R7
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CB_RXD_IRQ] && have_rx) |=> !irq_n); // R11
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[CB_RXD_IRQ] && !cfg_q[CB_TXE_IRQ]) |=> irq_n); // R11
  AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
    (commit_dat && thr_full && !tx_ready) |=> $stable(thr_word)); // R4
  AST_RTS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (commit_dat && rts_only && !thr_full) |=> !thr_full); // R5

endmodule

// File: rtl/spi_uart_regif.sv
module spi_uart_regif
  import spi_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              irq_n,
  output logic [CFG_W-1:0]  line_cfg,
  output logic              rts_out,
  input  logic              cts_in,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_word,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_word,
  input  logic              rx_ferr
);

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [1:0]        flags;
  logic [CFG_W-1:0]  payload;
  logic              frame_open, hdr_stb, done_q;
  op_e               hdr_op;
  logic [WORD_W-1:0] word_q;
  logic              fifo_flush, fifo_pop, fifo_single;
  rx_entry_t         fifo_head, fifo_din;
  logic [CW-1:0]     fifo_count;

  assign fifo_din = '{ferr: rx_ferr, chr: rx_word};

  uart_spi_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .sclk       (spi_sclk),
    .cs_n       (spi_cs_n),
    .mosi       (spi_mosi),
    .flags_in   (flags),
    .payload_in (payload),
    .miso       (spi_miso),
    .frame_open (frame_open),
    .hdr_stb    (hdr_stb),
    .hdr_op     (hdr_op),
    .done_q     (done_q),
    .word_q     (word_q)
  );

  uart_rx_queue #(.DEPTH(FIFO_DEPTH)) u_queue (
    .clk         (clk),
    .rst         (rst),
    .flush       (fifo_flush),
    .push        (rx_valid),
    .din         (fifo_din),
    .pop         (fifo_pop),
    .single_slot (fifo_single),
    .head        (fifo_head),
    .count       (fifo_count)
  );

  uart_spi_regs #(.DEPTH(FIFO_DEPTH)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .frame_open  (frame_open),
    .hdr_stb     (hdr_stb),
    .hdr_op      (hdr_op),
    .done_q      (done_q),
    .word_q      (word_q),
    .fifo_count  (fifo_count),
    .fifo_head   (fifo_head),
    .cts_in      (cts_in),
    .tx_ready    (tx_ready),
    .flags       (flags),
    .payload     (payload),
    .fifo_flush  (fifo_flush),
    .fifo_pop    (fifo_pop),
    .fifo_single (fifo_single),
    .cfg_q       (line_cfg),
    .rts_q       (rts_out),
    .thr_full    (tx_valid),
    .thr_word    (tx_word),
    .irq_n       (irq_n)
  );

endmodule

// File: tb/spi_uart_regif_tb_top.sv
module spi_uart_regif_tb_top;

  localparam int HALF = 6;
  localparam int NVEC = 6;
  // {frame sent, response expected}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h4000_4000,   // read cfg after reset
    32'hC473_4000,   // load cfg 0x0473
    32'h4000_4473,   // read it back
    32'h0000_4000,   // read data, empty queue
    32'hC000_4000,   // load cfg 0
    32'h4000_4000    // read it back
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, irq_n, rts_out, tx_valid;
  logic [13:0] line_cfg;
  logic [8:0]  tx_word;
  logic cts_in = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0, rx_ferr = 1'b0;
  logic [8:0] rx_word = '0;

  int n_run = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic [15:0] resp;

  always #4 clk = ~clk;

  spi_uart_regif dut_i (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_n(irq_n),
    .line_cfg(line_cfg), .rts_out(rts_out), .cts_in(cts_in),
    .tx_valid(tx_valid), .tx_word(tx_word), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_ferr(rx_ferr)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [15:0] tx, input int nbits, input logic inj,
                           input logic [9:0] inj_w, output logic [15:0] rx);
    rx = '0;
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 15; i >= 16 - nbits; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      if (inj && i == 0) begin
        repeat (3) @(negedge clk);
        rx_valid = 1'b1; {rx_ferr, rx_word} = inj_w;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (HALF - 4) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, output logic [15:0] rx);
    spi_frame(tx, 16, 1'b0, '0, rx);
  endtask

  task automatic push(input logic [9:0] w);
    @(negedge clk);
    rx_valid = 1'b1; {rx_ferr, rx_word} = w;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ready;
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R13 reset state
    check(line_cfg == 14'h0 && irq_n && !rts_out && !tx_valid && !spi_miso, "R13 reset",
          {line_cfg, irq_n, rts_out, tx_valid, spi_miso}, 32'h0000_0008);

    // R1 / R2 table of frames
    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][31:16], resp);
      check(resp == VEC[v][15:0], "R1/R2 table", resp, VEC[v][15:0]);
    end

    // R6 / R7 receive fields, CTS, empty read
    cts_in = 1'b1;
    push({1'b0, 1'b1, 8'h41});
    push({1'b1, 1'b0, 8'h7E});
    xfer(16'h0000, resp); check(resp == 16'hC341, "R6 char+parity+cts", resp, 16'hC341);
    xfer(16'h0000, resp); check(resp == 16'hC67E, "R6 framing error", resp, 16'hC67E);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R7 empty read", resp, 16'h4200);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R7 empty read twice", resp, 16'h4200);

    // R4 / R5 transmit path
    xfer(16'h8355, resp); check(resp == 16'h4000, "R2 write response", resp, 16'h4000);
    check(tx_valid && tx_word == 9'h155, "R4 queued", {tx_valid, tx_word}, {1'b1, 9'h155});
    check(rts_out == 1'b1, "R5 rts set", rts_out, 1);
    xfer(16'h4000, resp); check(resp == 16'h0000, "R2 tx busy flag", resp, 16'h0000);
    xfer(16'h80AA, resp);
    check(tx_valid && tx_word == 9'h155, "R4 drop when full", tx_word, 9'h155);
    pulse_ready;
    check(!tx_valid, "R4 taken by engine", tx_valid, 0);
    xfer(16'h8433, resp);
    check(!tx_valid && !rts_out, "R5 rts-only", {tx_valid, rts_out}, 0);

    // R8 depth and order
    for (int i = 0; i < 17; i++) push({2'b00, 8'(i)});
    for (int i = 0; i < 16; i++) begin
      xfer(16'h0000, resp);
      check(resp == (16'hC200 | 16'(i)), "R8 order", resp, 16'hC200 | 16'(i));
    end
    xfer(16'h0000, resp); check(resp == 16'h4200, "R8 overflow dropped", resp, 16'h4200);

    // R3 flush
    push(10'h001); push(10'h002); push(10'h003);
    xfer(16'hC000, resp); check(resp == 16'hC000, "R3 flags on cfg write", resp, 16'hC000);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R3 flushed", resp, 16'h4200);

    // R9 single slot
    xfer(16'hE000, resp);
    check(line_cfg == 14'h2000, "R9 cfg out", line_cfg, 14'h2000);
    push(10'h011); push(10'h022);
    xfer(16'h0000, resp); check(resp == 16'hC211, "R9 first kept", resp, 16'hC211);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R9 second dropped", resp, 16'h4200);
    xfer(16'hC000, resp);

    // R10 aborted frames
    push(10'h05A);
    spi_frame(16'hFFFF, 10, 1'b0, '0, resp);
    xfer(16'h4000, resp); check(resp == 16'hC000, "R10 cfg untouched", resp, 16'hC000);
    spi_frame(16'h0000, 8, 1'b0, '0, resp);
    xfer(16'h0000, resp); check(resp == 16'hC25A, "R10 no pop on abort", resp, 16'hC25A);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R10 then empty", resp, 16'h4200);

    // R11 interrupt
    xfer(16'hC400, resp);
    check(irq_n == 1'b1, "R11 rx mask, empty", irq_n, 1);
    push(10'h077);
    check(irq_n == 1'b0, "R11 rx pending", irq_n, 0);
    xfer(16'h0000, resp);
    check(irq_n == 1'b1, "R11 rx drained", irq_n, 1);
    xfer(16'hC800, resp);
    check(irq_n == 1'b0, "R11 tx empty", irq_n, 0);
    xfer(16'h8011, resp);
    check(irq_n == 1'b1, "R11 tx busy", irq_n, 1);
    pulse_ready;
    check(irq_n == 1'b0, "R11 tx empty again", irq_n, 0);
    xfer(16'hC000, resp);
    check(irq_n == 1'b1, "R11 masked", irq_n, 1);

    // R12 same-cycle collisions
    push(10'h001); push(10'h002);
    spi_frame(16'hC000, 16, 1'b1, 10'h03C, resp);
    xfer(16'h0000, resp); check(resp == 16'hC23C, "R12 flush keeps new", resp, 16'hC23C);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R12 flush only one", resp, 16'h4200);
    push(10'h044);
    spi_frame(16'h0000, 16, 1'b1, 10'h055, resp);
    check(resp == 16'hC244, "R12 pop head", resp, 16'hC244);
    xfer(16'h0000, resp); check(resp == 16'hC255, "R12 push kept", resp, 16'hC255);
    xfer(16'h0000, resp); check(resp == 16'h4200, "R12 then empty", resp, 16'h4200);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule